// File: doc/BRIEF.md
# Shared PLL Vote Arbiter

This block lets several independent masters share one PLL. Every master owns one bit of a vote word and raises a one-cycle request or release pulse to set or clear that bit. The arbiter keeps an on flag that is separate from the vote word. The first vote that makes the word non-zero turns the PLL request on. The release that empties the word turns it off. Every switch-on launches a bounded lock poll. The poll samples the PLL ready input once per divided tick. It ends with a one-cycle `done` pulse, or with an `err` pulse when the tick budget runs out.

The vote bit of the local processor is not driven from the master ports. A software-level stage sits in front of it and gathers votes from several local sub-requesters into a mask. The stage raises the local hardware vote only when its mask is empty, and sets a sub-requester's mask bit only after the poll reports lock. It drops the local vote when its mask empties again. All vote updates in one cycle are merged into a single register write, so no update can be lost between masters.

Top module: `pll_vote_ctrl`

## Requirements
- R1: After reset `vote_word`, `sub_mask`, `pll_on`, `done`, `err`, `sub_done` and `sub_err` are all zero.
- R2: A pulse on `vote_req[i]` sets bit i of `vote_word` at the next clock edge. A pulse on `vote_rel[i]` clears it. No other bit changes.
- R3: When the vote word goes from zero to non-zero, `pll_on` rises at the same edge that records the vote, and a lock poll starts at that edge.
- R4: When the vote word becomes zero and no poll is running, `pll_on` falls at the same edge that records the word.
- R5: A poll samples `pll_ready` every TICK_DIV cycles, with the first sample TICK_DIV cycles after launch. If the k-th sample sees ready, `done` pulses k*TICK_DIV edges after `pll_on` rose.
- R6: If ready is not seen in POLL_LIMIT samples, `err` pulses POLL_LIMIT*TICK_DIV edges after launch. `done` stays low, and `pll_on` and the vote word are kept.
- R7: While a poll is running, an empty vote word does not clear `pll_on`. The stop takes effect at the edge after the `done` or `err` pulse.
- R8: Request and release from different masters in the same cycle are both applied, and the start/stop decision uses the merged word. A request and a release from the same master in one cycle leave its bit set.
- R9: A release from a master whose bit is already clear changes neither `vote_word` nor `pll_on`.
- R10: Bit LOCAL_ID (default 1) of `vote_req`/`vote_rel` is ignored. That vote bit is driven only by the software-level stage.
- R11: A sub-request while `sub_mask` is zero sets vote bit LOCAL_ID at the next edge and waits for the poll. On `done`, the sub-requester's mask bit and a `sub_done` pulse appear one edge later.
- R12: A sub-request while `sub_mask` is non-zero sets its mask bit and pulses `sub_done` at the next edge, without starting a poll.
- R13: A sub-release that empties `sub_mask` clears vote bit LOCAL_ID at the same edge. A sub-release that leaves other mask bits set keeps that vote.
- R14: If the poll behind a pending sub-request ends in `err`, `sub_err` pulses one edge later, `sub_mask` stays zero and vote bit LOCAL_ID is dropped at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vote_req | input | NUM_MASTERS | One-cycle vote set pulse per master |
| vote_rel | input | NUM_MASTERS | One-cycle vote clear pulse per master |
| sub_req | input | NUM_SUBS | Software-level vote request pulse per local sub-requester |
| sub_rel | input | NUM_SUBS | Software-level vote release pulse per local sub-requester |
| pll_ready | input | 1 | Lock/ready status from the PLL |
| vote_word | output | NUM_MASTERS | Current hardware vote word |
| pll_on | output | 1 | On flag, used as the PLL enable request |
| done | output | 1 | Pulse: poll saw ready |
| err | output | 1 | Pulse: poll timed out |
| sub_mask | output | NUM_SUBS | Software-level vote mask |
| sub_done | output | 1 | Pulse: a sub-request was granted |
| sub_err | output | 1 | Pulse: a pending sub-request failed on timeout |

## Verification
The assertions check on every cycle that the PLL request only rises on a non-zero vote word and only falls on an empty one. They also check that the request stays on through a running poll, that `done` and `err` never coincide, and that the software mask is never non-zero without the local vote. The exact poll latencies, the timeout count and the deferred stop after a timeout need the bench's scenarios. So do the ignored local port bit, the merging of same-cycle requests and releases, and the grant or failure sequence of the software-level stage.

// File: rtl/pll_vote_pkg.sv
package pll_vote_pkg;

   typedef enum logic [0:0] {
      SV_IDLE = 1'b0,
      SV_WAIT = 1'b1
   } soft_state_e;

   typedef struct packed {
      logic done;
      logic err;
   } poll_result_t;

endpackage

// File: rtl/pvc_lock_poll.sv
module pvc_lock_poll
   import pll_vote_pkg::*;
#(
   parameter int TICK_DIV   = 50,
   parameter int POLL_LIMIT = 200,
   parameter int READY_SYNC = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         launch,
   input  logic         ready_in,
   output logic         busy,
   output poll_result_t res
);

   localparam int DIV_W = $clog2(TICK_DIV + 1);
   localparam int CNT_W = $clog2(POLL_LIMIT + 1);

   logic             rdy;
   logic [DIV_W-1:0] div_q;
   logic [CNT_W-1:0] tick_q;

   // optional ready synchroniser, chosen by parameter
   generate
      if (READY_SYNC == 0) begin : g_direct
         assign rdy = ready_in;
      end else begin : g_sync
         logic [READY_SYNC-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh_q <= '0;
            end else begin
               sh_q[0] <= ready_in;
               for (int i = 1; i < READY_SYNC; i++) begin
                  sh_q[i] <= sh_q[i-1];
               end
            end
         end
         assign rdy = sh_q[READY_SYNC-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         div_q  <= '0;
         tick_q <= '0;
         res    <= '0;
      end else begin
         res <= '0;
         if (!busy) begin
            if (launch) begin
               busy   <= 1'b1;
               div_q  <= '0;
               tick_q <= '0;
            end
         end else if (div_q == DIV_W'(TICK_DIV - 1)) begin
            div_q <= '0;
            if (rdy) begin
               busy     <= 1'b0;
               res.done <= 1'b1;
            end else if (tick_q == CNT_W'(POLL_LIMIT - 1)) begin
               busy    <= 1'b0;
               res.err <= 1'b1;
            end else begin
               tick_q <= tick_q + 1'b1;
            end
         end else begin
            div_q <= div_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/pvc_vote_core.sv
module pvc_vote_core #(
   parameter int NUM_MASTERS = 4,
   parameter int LOCAL_ID    = 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_MASTERS-1:0] ext_req,
   input  logic [NUM_MASTERS-1:0] ext_rel,
   input  logic                   loc_set,
   input  logic                   loc_clr,
   input  logic                   poll_busy,
   output logic [NUM_MASTERS-1:0] vote,
   output logic                   on,
   output logic                   start
);

   logic [NUM_MASTERS-1:0] set_b;
   logic [NUM_MASTERS-1:0] clr_b;
   logic [NUM_MASTERS-1:0] vote_nx;
   logic                   stop;

   // per-bit owner: the local bit belongs to the software stage
   generate
      for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_bit
         if (g == LOCAL_ID) begin : g_loc
            logic unused_loc_port;
            assign unused_loc_port = ext_req[g] | ext_rel[g];
            assign set_b[g] = loc_set;
            assign clr_b[g] = loc_clr;
         end else begin : g_ext
            assign set_b[g] = ext_req[g];
            assign clr_b[g] = ext_rel[g] & ~ext_req[g];
         end
      end
   endgenerate

   always_comb begin
      vote_nx = (vote & ~clr_b) | set_b;
      start   = !on && (|vote_nx);
      stop    = on && !poll_busy && !(|vote_nx);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vote <= '0;
         on   <= 1'b0;
      end else begin
         vote <= vote_nx;
         if (start) begin
            on <= 1'b1;
         end else if (stop) begin
            on <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/pvc_soft_vote.sv
module pvc_soft_vote
   import pll_vote_pkg::*;
#(
   parameter int NUM_SUBS = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SUBS-1:0] sub_req,
   input  logic [NUM_SUBS-1:0] sub_rel,
   input  poll_result_t        poll_res,
   output logic [NUM_SUBS-1:0] mask,
   output logic                loc_set,
   output logic                loc_clr,
   output logic                grant,
   output logic                fail
);

   soft_state_e         st_q, st_nx;
   logic [NUM_SUBS-1:0] pend_q, pend_nx, mask_nx;
   logic                grant_nx, fail_nx;

   always_comb begin
      st_nx    = st_q;
      pend_nx  = pend_q;
      mask_nx  = mask;
      loc_set  = 1'b0;
      loc_clr  = 1'b0;
      grant_nx = 1'b0;
      fail_nx  = 1'b0;
      case (st_q)
         SV_IDLE: begin
            if (mask == '0) begin
               if (|sub_req) begin
                  pend_nx = sub_req;
                  st_nx   = SV_WAIT;
                  loc_set = 1'b1;
               end
            end else begin
               mask_nx  = (mask & ~sub_rel) | sub_req;
               grant_nx = |sub_req;
               loc_clr  = (mask_nx == '0);
            end
         end
         SV_WAIT: begin
            pend_nx = (pend_q & ~sub_rel) | sub_req;
            if (poll_res.done) begin
               st_nx = SV_IDLE;
               if (pend_nx != '0) begin
                  mask_nx  = pend_nx;
                  grant_nx = 1'b1;
               end else begin
                  loc_clr = 1'b1;
               end
               pend_nx = '0;
            end else if (poll_res.err) begin
               st_nx   = SV_IDLE;
               loc_clr = 1'b1;
               fail_nx = 1'b1;
               pend_nx = '0;
            end
         end
         default: st_nx = SV_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SV_IDLE;
         pend_q <= '0;
         mask   <= '0;
         grant  <= 1'b0;
         fail   <= 1'b0;
      end else begin
         st_q   <= st_nx;
         pend_q <= pend_nx;
         mask   <= mask_nx;
         grant  <= grant_nx;
         fail   <= fail_nx;
      end
   end

endmodule

// File: rtl/pll_vote_ctrl.sv
module pll_vote_ctrl
   import pll_vote_pkg::*;
#(
   parameter int NUM_MASTERS = 4,
   parameter int LOCAL_ID    = 1,
   parameter int NUM_SUBS    = 4,
   parameter int TICK_DIV    = 50,
   parameter int POLL_LIMIT  = 200,
   parameter int READY_SYNC  = 0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_MASTERS-1:0] vote_req,
   input  logic [NUM_MASTERS-1:0] vote_rel,
   input  logic [NUM_SUBS-1:0]    sub_req,
   input  logic [NUM_SUBS-1:0]    sub_rel,
   input  logic                   pll_ready,
   output logic [NUM_MASTERS-1:0] vote_word,
   output logic                   pll_on,
   output logic                   done,
   output logic                   err,
   output logic [NUM_SUBS-1:0]    sub_mask,
   output logic                   sub_done,
   output logic                   sub_err
);

   // elaboration-time parameter checks
   generate
      if (NUM_MASTERS < 2) begin : g_bad_masters
         $error("NUM_MASTERS must be at least 2");
      end
      if (LOCAL_ID < 0 || LOCAL_ID >= NUM_MASTERS) begin : g_bad_local
         $error("LOCAL_ID must index a vote bit");
      end
      if (NUM_SUBS < 1) begin : g_bad_subs
         $error("NUM_SUBS must be at least 1");
      end
      if (TICK_DIV < 1 || POLL_LIMIT < 1) begin : g_bad_poll
         $error("TICK_DIV and POLL_LIMIT must be positive");
      end
      if (READY_SYNC < 0) begin : g_bad_sync
         $error("READY_SYNC must not be negative");
      end
   endgenerate

   logic         loc_set, loc_clr;
   logic         start, poll_busy, launch;
   poll_result_t poll_res;

   pvc_vote_core #(
      .NUM_MASTERS (NUM_MASTERS),
      .LOCAL_ID    (LOCAL_ID)
   ) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .ext_req   (vote_req),
      .ext_rel   (vote_rel),
      .loc_set   (loc_set),
      .loc_clr   (loc_clr),
      .poll_busy (poll_busy),
      .vote      (vote_word),
      .on        (pll_on),
      .start     (start)
   );

   // a poll runs on every switch-on and on every first local vote
   assign launch = !poll_busy && (start || loc_set);

   pvc_lock_poll #(
      .TICK_DIV   (TICK_DIV),
      .POLL_LIMIT (POLL_LIMIT),
      .READY_SYNC (READY_SYNC)
   ) u_poll (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch   (launch),
      .ready_in (pll_ready),
      .busy     (poll_busy),
      .res      (poll_res)
   );

   pvc_soft_vote #(
      .NUM_SUBS (NUM_SUBS)
   ) u_soft (
      .clk      (clk),
      .rst_n    (rst_n),
      .sub_req  (sub_req),
      .sub_rel  (sub_rel),
      .poll_res (poll_res),
      .mask     (sub_mask),
      .loc_set  (loc_set),
      .loc_clr  (loc_clr),
      .grant    (sub_done),
      .fail     (sub_err)
   );

   assign done = poll_res.done;
   assign err  = poll_res.err;

endmodule

// File: rtl/pll_vote_ctrl_chk.sv
module pll_vote_ctrl_chk #(
   parameter int NUM_MASTERS = 4,
   parameter int LOCAL_ID    = 1,
   parameter int NUM_SUBS    = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NUM_MASTERS-1:0] vote_word,
   input logic                   pll_on,
   input logic                   done,
   input logic                   err,
   input logic [NUM_SUBS-1:0]    sub_mask,
   input logic                   poll_busy
);

   // R3: switch-on only with a live vote
   a_r3_on_needs_vote: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pll_on) |-> (vote_word != '0));

   // R4: switch-off only with an empty vote word
   a_r4_off_needs_empty: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pll_on) |-> (vote_word == '0));

   // R7: a running poll keeps the request on
   a_r7_poll_holds_on: assert property (@(posedge clk) disable iff (!rst_n)
      poll_busy |-> pll_on);

   // R5, R6: one outcome per poll
   a_r6_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err));

   // R5: done is a single-cycle pulse
   a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11, R13: a granted software vote implies the local hardware vote
   a_r13_mask_has_vote: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_mask != '0) |-> vote_word[LOCAL_ID]);

   // R10: the local vote appears only while the software mask is empty
   a_r10_local_from_soft: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vote_word[LOCAL_ID]) |-> (sub_mask == '0));

endmodule

bind pll_vote_ctrl pll_vote_ctrl_chk #(
   .NUM_MASTERS (NUM_MASTERS),
   .LOCAL_ID    (LOCAL_ID),
   .NUM_SUBS    (NUM_SUBS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .vote_word (vote_word),
   .pll_on    (pll_on),
   .done      (done),
   .err       (err),
   .sub_mask  (sub_mask),
   .poll_busy (poll_busy)
);

// File: tb/test_pll_vote_ctrl.sv
module test_pll_vote_ctrl;

   localparam int N  = 4;
   localparam int S  = 2;
   localparam int LI = 1;
   localparam int T  = 4;
   localparam int P  = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] vote_req = '0, vote_rel = '0;
   logic [S-1:0] sub_req = '0, sub_rel = '0;
   logic         pll_ready = 1'b1;
   logic [N-1:0] vote_word;
   logic         pll_on, done, err, sub_done, sub_err;
   logic [S-1:0] sub_mask;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   pll_vote_ctrl #(
      .NUM_MASTERS (N), .LOCAL_ID (LI), .NUM_SUBS (S),
      .TICK_DIV (T), .POLL_LIMIT (P), .READY_SYNC (0)
   ) i_pll_vote_ctrl (
      .clk (clk), .rst_n (rst_n), .vote_req (vote_req), .vote_rel (vote_rel),
      .sub_req (sub_req), .sub_rel (sub_rel), .pll_ready (pll_ready),
      .vote_word (vote_word), .pll_on (pll_on), .done (done), .err (err),
      .sub_mask (sub_mask), .sub_done (sub_done), .sub_err (sub_err)
   );

   // {req, rel, expected vote word, expected pll_on}
   localparam logic [12:0] VEC [10] = '{
      {4'b0001, 4'b0000, 4'b0001, 1'b1},
      {4'b0100, 4'b0000, 4'b0101, 1'b1},
      {4'b0000, 4'b0001, 4'b0100, 1'b1},
      {4'b0000, 4'b0001, 4'b0100, 1'b1},
      {4'b1000, 4'b0100, 4'b1000, 1'b1},
      {4'b0000, 4'b1000, 4'b0000, 1'b0},
      {4'b0010, 4'b0000, 4'b0000, 1'b0},
      {4'b1101, 4'b0000, 4'b1101, 1'b1},
      {4'b0001, 4'b0001, 4'b1101, 1'b1},
      {4'b0000, 4'b1101, 4'b0000, 1'b0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic pulse_vote(input logic [N-1:0] rq, input logic [N-1:0] rl);
      vote_req = rq; vote_rel = rl;
      @(negedge clk);
      vote_req = '0; vote_rel = '0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 vote", 32'(vote_word), 0);
      chk("R1 on", 32'(pll_on), 0);
      chk("R1 pulses", 32'({done, err, sub_done, sub_err}), 0);
      chk("R1 mask", 32'(sub_mask), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk: R2 R3 R4 R8 R9 R10
      for (int i = 0; i < 10; i++) begin
         pulse_vote(VEC[i][12:9], VEC[i][8:5]);
         repeat (T + 3) @(negedge clk);
         chk($sformatf("R2/R8/R9/R10 vec%0d vote", i), 32'(vote_word), 32'(VEC[i][4:1]));
         chk($sformatf("R3/R4 vec%0d on", i), 32'(pll_on), 32'(VEC[i][0]));
      end

      // R3 R5: immediate ready, done after T edges
      pll_ready = 1'b1;
      pulse_vote(4'b0001, 4'b0000);
      chk("R3 on at vote edge", 32'(pll_on), 1);
      n = 0;
      while (!done && n < 1000) begin @(negedge clk); n++; end
      chk("R5 done latency", 32'(n), T);
      pulse_vote(4'b0000, 4'b0001);
      chk("R4 off at empty edge", 32'(pll_on), 0);

      // R5: ready seen on the 4th sample
      pll_ready = 1'b0;
      pulse_vote(4'b0100, 4'b0000);
      n = 0;
      while (!done && n < 1000) begin
         @(negedge clk); n++;
         if (n == 3 * T + 1) pll_ready = 1'b1;
      end
      chk("R5 late ready latency", 32'(n), 4 * T);
      pulse_vote(4'b0000, 4'b0100);
      @(negedge clk);

      // R6: timeout keeps votes and on flag
      pll_ready = 1'b0;
      pulse_vote(4'b0100, 4'b0000);
      n = 0;
      while (!err && n < 1000) begin
         @(negedge clk); n++;
         if (done) chk("R6 no done", 1, 0);
      end
      chk("R6 timeout latency", 32'(n), P * T);
      chk("R6 on kept", 32'(pll_on), 1);
      chk("R6 vote kept", 32'(vote_word), 32'h4);
      pulse_vote(4'b0000, 4'b0100);
      chk("R4 off after timeout", 32'(pll_on), 0);

      // R7: stop deferred while polling
      pulse_vote(4'b0001, 4'b0000);
      @(negedge clk);
      pulse_vote(4'b0000, 4'b0001);
      repeat (3) @(negedge clk);
      chk("R7 held vote", 32'(vote_word), 0);
      chk("R7 held on", 32'(pll_on), 1);
      while (!err) @(negedge clk);
      chk("R7 on at result", 32'(pll_on), 1);
      @(negedge clk);
      chk("R7 off after result", 32'(pll_on), 0);

      // R11: first sub-request waits for lock
      pll_ready = 1'b1;
      sub_req = 2'b01; @(negedge clk); sub_req = '0;
      chk("R11 local vote", 32'(vote_word[LI]), 1);
      chk("R11 mask pending", 32'(sub_mask), 0);
      n = 1;
      while (!sub_done && n < 1000) begin @(negedge clk); n++; end
      chk("R11 grant latency", 32'(n), T + 2);
      chk("R11 mask", 32'(sub_mask), 1);

      // R12: second sub-request granted at once, no poll
      sub_req = 2'b10; @(negedge clk); sub_req = '0;
      chk("R12 grant", 32'(sub_done), 1);
      chk("R12 mask", 32'(sub_mask), 3);
      repeat (T + 1) begin
         @(negedge clk);
         if (done) chk("R12 no poll", 1, 0);
      end

      // R13: releases
      sub_rel = 2'b01; @(negedge clk); sub_rel = '0;
      chk("R13 partial mask", 32'(sub_mask), 2);
      chk("R13 vote kept", 32'(vote_word[LI]), 1);
      sub_rel = 2'b10; @(negedge clk); sub_rel = '0;
      chk("R13 mask empty", 32'(sub_mask), 0);
      chk("R13 vote dropped", 32'(vote_word[LI]), 0);
      chk("R13 pll off", 32'(pll_on), 0);

      // R14: failed sub-request
      pll_ready = 1'b0;
      sub_req = 2'b10; @(negedge clk); sub_req = '0;
      while (!sub_err) @(negedge clk);
      chk("R14 mask", 32'(sub_mask), 0);
      chk("R14 vote dropped", 32'(vote_word[LI]), 0);
      chk("R14 pll off", 32'(pll_on), 0);

      finish_run();
   end

endmodule